// File: doc/BRIEF.md
# Four-Channel Timer/Counter Unit

The block holds four down-counting channels driven by a shared clock-enable tick. Software writes a start/reload value per channel and a single control register that enables each channel and selects, per channel, between a one-shot counter that stops when it expires and a periodic timer that reloads itself and keeps running. Each time a channel expires, a one-cycle event is raised on that channel's output bit, which feeds an interrupt controller.

Channel 0 is wider than channels 1 to 3, and each channel keeps only as many bits as its width. A channel whose enable is cleared pauses and keeps its remaining count. Setting the enable again either resumes from that count or, if nothing remains, starts a fresh count from the channel's register. A reload value of zero never starts a channel, so it cannot cause an endless run of expiries. A read of a channel address returns the remaining count while one exists, so software sees the count go down live.

Top module: `tmr4_unit`

## Requirements
- R1: After reset every count register, every remaining count and the control register read 0, and `expire_o` is 0.
- R2: A write to address n (0..3) stores the low CH0_W bits of the data for channel 0 and the low CHN_W bits for channels 1..3. The upper bits read back as 0.
- R3: Control bit 2n enables channel n. When this bit goes from 0 to 1 and the remaining count is zero, the channel loads its count register value N (N > 0) and starts. `expire_o[n]` is high for exactly one cycle, in the cycle after the Nth tick cycle.
- R4: When control bit 2n+1 is 1 (timer mode) and the channel expires with a nonzero count register, it reloads that value and keeps counting, so it expires every N ticks.
- R5: When control bit 2n+1 is 0 (counter mode), the channel stops after it expires with a remaining count of 0. It gives no further expiry until its enable goes from 0 to 1 again. The enable bit stays set in the control register.
- R6: A read of address n returns channel n's remaining count when that count is nonzero, and the count register value otherwise. A read of address 4 returns the control register in bits 7:0. Any other address reads 0.
- R7: When enable bit 2n goes from 1 to 0, channel n stops counting and keeps its remaining count. When the bit is set again, counting resumes from that count.
- R8: A count register value of zero never starts a channel. A timer-mode channel that expires while its count register holds zero stops instead of reloading.
- R9: Counting advances only in cycles where `tick_i` is high. Cycles without a tick leave every remaining count unchanged.
- R10: The channels run independently. Channels that expire on the same tick each pulse their own `expire_o` bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count enable, one step per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address: 0..3 count registers, 4 control |
| wr_data_i | input | DW | Write data |
| rd_addr_i | input | 3 | Read address, same map as writes |
| rd_data_o | output | DW | Read data, combinational from `rd_addr_i` |
| expire_o | output | 4 | Per-channel one-cycle expiry event |

## Verification
The bench builds the unit with DW=32, CH0_W=16 and CHN_W=8. With these widths, writes of a full 32-bit pattern show truncation at two different widths. The counts stay short enough that periodic reloads, pause and resume, and expiries on two channels in the same cycle can all be reached in a few hundred cycles. A reference model in the bench follows the requirements and predicts each expiry cycle and each read value. This covers the zero-reload guard both at start and at a timer-mode expiry.

// File: rtl/tmr4_pkg.sv
package tmr4_pkg;
  localparam int unsigned CH_NUM = 4;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned CTRL_W = 2 * CH_NUM;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 3'd4;

  function automatic int unsigned chan_w(int unsigned n, int unsigned w0, int unsigned wn);
    return (n == 0) ? w0 : wn;
  endfunction
endpackage

// File: rtl/tmr4_regs.sv
module tmr4_regs
  import tmr4_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned CH0_W = 32,
  parameter int unsigned CHN_W = 24
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DW-1:0]              wr_data_i,
  output logic [CTRL_W-1:0]          ctrl_o,
  output logic [CH_NUM-1:0][DW-1:0]  reload_o,
  output logic [CH_NUM-1:0]          en_set_o,
  output logic [CH_NUM-1:0]          en_clr_o,
  output logic [CH_NUM-1:0]          mode_o
);
  logic ctrl_wr;
  logic [CTRL_W-1:0] ctrl_q;

  assign ctrl_wr = wr_en_i && (wr_addr_i == CTRL_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wr_data_i[CTRL_W-1:0];
  end

  assign ctrl_o = ctrl_q;

  for (genvar n = 0; n < CH_NUM; n++) begin : g_ch
    localparam int unsigned CW = chan_w(n, CH0_W, CHN_W);
    localparam logic [DW-1:0] MASK = ~({DW{1'b1}} << CW);
    logic [DW-1:0] rld_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        rld_q <= '0;
      else if (wr_en_i && (wr_addr_i == ADDR_W'(n)))
        rld_q <= wr_data_i & MASK;
    end

    assign reload_o[n] = rld_q;
    // enable edges are taken from the write itself, not from the stored bit
    assign en_set_o[n] = ctrl_wr && !ctrl_q[2*n] &&  wr_data_i[2*n];
    assign en_clr_o[n] = ctrl_wr &&  ctrl_q[2*n] && !wr_data_i[2*n];
    assign mode_o[n]   = ctrl_q[2*n+1];
  end
endmodule

// File: rtl/tmr4_chan.sv
module tmr4_chan #(
  parameter int unsigned CW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          en_set_i,
  input  logic          en_clr_i,
  input  logic          mode_i,
  input  logic [CW-1:0] reload_i,
  output logic [CW-1:0] live_o,
  output logic          active_o,
  output logic          expire_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_o   <= '0;
      active_o <= 1'b0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (en_clr_i) begin
        active_o <= 1'b0;                 // pause, count kept
      end else if (en_set_i) begin
        if (live_o != '0) begin
          active_o <= 1'b1;               // resume
        end else if (reload_i != '0) begin
          live_o   <= reload_i;
          active_o <= 1'b1;
        end
      end else if (tick_i && active_o) begin
        if (live_o == ONE) begin
          expire_o <= 1'b1;
          if (mode_i && (reload_i != '0)) begin
            live_o <= reload_i;
          end else begin
            live_o   <= '0;
            active_o <= 1'b0;
          end
        end else begin
          live_o <= live_o - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/tmr4_unit.sv
module tmr4_unit
  import tmr4_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned CH0_W = 32,
  parameter int unsigned CHN_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DW-1:0]     rd_data_o,
  output logic [CH_NUM-1:0] expire_o
);
  logic [CTRL_W-1:0]         ctrl;
  logic [CH_NUM-1:0][DW-1:0] rld_pad;
  logic [CH_NUM-1:0][DW-1:0] live_pad;
  logic [CH_NUM-1:0]         en_set;
  logic [CH_NUM-1:0]         en_clr;
  logic [CH_NUM-1:0]         chan_mode;
  logic [CH_NUM-1:0]         chan_act;

  tmr4_regs #(.DW(DW), .CH0_W(CH0_W), .CHN_W(CHN_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .ctrl_o   (ctrl),
    .reload_o (rld_pad),
    .en_set_o (en_set),
    .en_clr_o (en_clr),
    .mode_o   (chan_mode)
  );

  for (genvar n = 0; n < CH_NUM; n++) begin : g_ch
    localparam int unsigned CW = chan_w(n, CH0_W, CHN_W);
    logic [CW-1:0] live_w;

    tmr4_chan #(.CW(CW)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .en_set_i(en_set[n]),
      .en_clr_i(en_clr[n]),
      .mode_i  (chan_mode[n]),
      .reload_i(rld_pad[n][CW-1:0]),
      .live_o  (live_w),
      .active_o(chan_act[n]),
      .expire_o(expire_o[n])
    );

    assign live_pad[n] = DW'(live_w);
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == CTRL_ADDR) rd_data_o = DW'(ctrl);
    for (int n = 0; n < CH_NUM; n++) begin
      if (rd_addr_i == ADDR_W'(n))
        rd_data_o = (live_pad[n] != '0) ? live_pad[n] : rld_pad[n];
    end
  end
endmodule

// File: rtl/tmr4_unit_chk.sv
module tmr4_unit_chk
  import tmr4_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      tick_i,
  input logic [CH_NUM-1:0]         expire_o,
  input logic [CH_NUM-1:0]         act_i,
  input logic [CH_NUM-1:0]         mode_i,
  input logic [CH_NUM-1:0][DW-1:0] live_i,
  input logic [CH_NUM-1:0][DW-1:0] rld_i
);
  for (genvar n = 0; n < CH_NUM; n++) begin : g_ch
    AST_EXP_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_o[n] |-> $past(tick_i) && $past(act_i[n])); // R9

    AST_TIMER_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_o[n] && $past(mode_i[n]) && ($past(rld_i[n]) != '0)
        |-> act_i[n] && (live_i[n] == $past(rld_i[n]))); // R4

    AST_COUNTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_o[n] && !$past(mode_i[n]) |-> !act_i[n] && (live_i[n] == '0)); // R5

    AST_ACTIVE_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_i[n] |-> (live_i[n] != '0)); // R8

    AST_PAUSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !act_i[n] && $past(!act_i[n]) |-> $stable(live_i[n])); // R7
  end
endmodule

bind tmr4_unit tmr4_unit_chk #(.DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .expire_o(expire_o),
  .act_i   (chan_act),
  .mode_i  (chan_mode),
  .live_i  (live_pad),
  .rld_i   (rld_pad)
);

// File: tb/tmr4_unit_test.sv
`timescale 1ns/1ps
module tmr4_unit_test;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [2:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [3:0]    expire;

  always #2 clk = ~clk;

  tmr4_unit #(.DW(DW), .CH0_W(16), .CHN_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .expire_o(expire)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit run = 1'b0;
  bit done = 1'b0;

  typedef struct { int at; int ch; string tag; } exp_t;
  exp_t q[$];

  logic [31:0] m_reg  [4];
  logic [31:0] m_live [4];
  bit          m_act  [4];
  logic [7:0]  m_ctrl;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  function automatic logic [31:0] mask(int n);
    return (n == 0) ? 32'h0000_FFFF : 32'h0000_00FF;
  endfunction

  // monitor: compares expiry pulses against the scoreboard queue
  always @(negedge clk) begin
    logic [3:0] want;
    string t;
    if (run) begin
      want = '0;
      t = "R10 unexpected expiry";
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].at == cyc) begin
          want[q[i].ch] = 1'b1;
          t = q[i].tag;
          q.delete(i);
        end
      end
      if (want != 0 || expire != 0) chk(expire == want, t, 32'(expire), 32'(want));
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d; tick = 1'b0;
    if (a < 4) m_reg[a] = d & mask(a);
    else if (a == 4) begin
      for (int n = 0; n < 4; n++) begin
        if (m_ctrl[2*n] && !d[2*n]) m_act[n] = 1'b0;
        else if (!m_ctrl[2*n] && d[2*n]) begin
          if (m_live[n] != 0) m_act[n] = 1'b1;
          else if (m_reg[n] != 0) begin m_live[n] = m_reg[n]; m_act[n] = 1'b1; end
        end
      end
      m_ctrl = d[7:0];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input bit tk, input string tag);
    tick = tk;
    if (tk) begin
      for (int n = 0; n < 4; n++) begin
        if (m_act[n]) begin
          if (m_live[n] == 1) begin
            q.push_back('{cyc + 1, n, tag});
            if (m_ctrl[2*n+1] && m_reg[n] != 0) m_live[n] = m_reg[n];
            else begin m_live[n] = 0; m_act[n] = 1'b0; end
          end else m_live[n] = m_live[n] - 1;
        end
      end
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic ticks(input int k, input string tag);
    for (int i = 0; i < k; i++) step(1'b1, tag);
  endtask

  task automatic rd(input int a, input string tag);
    logic [31:0] exp;
    rd_addr = 3'(a);
    #1;
    if (a < 4) exp = (m_live[a] != 0) ? m_live[a] : m_reg[a];
    else if (a == 4) exp = 32'(m_ctrl);
    else exp = 0;
    chk(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 4; n++) begin m_reg[n] = 0; m_live[n] = 0; m_act[n] = 0; end
    m_ctrl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) rd(a, "R1 reset read");
    chk(expire == 0, "R1 expire after reset", 32'(expire), 0);

    // R2 width masking
    for (int a = 0; a < 4; a++) wr(a, 32'hDEAD_BEEF);
    for (int a = 0; a < 4; a++) rd(a, "R2 masked readback");
    rd(6, "R6 unused address");

    // R3 one-shot start, R6 live read, R9 tick gating
    wr(0, 5);
    wr(4, 8'h01);
    rd(4, "R6 control read");
    ticks(2, "R3 expiry timing");
    rd(0, "R6 live count");
    step(1'b0, "R9"); step(1'b0, "R9");
    rd(0, "R9 no tick hold");
    ticks(3, "R3 expiry timing");
    rd(0, "R5 stopped reads register");
    ticks(6, "R5 no re-expiry");
    rd(0, "R5 after idle ticks");
    rd(4, "R5 enable bit kept");

    // R4 periodic timer on channel 1
    wr(1, 3);
    wr(4, 8'h0D);
    ticks(10, "R4 periodic reload");
    rd(1, "R6 live during timer");

    // R7 pause and resume on channel 2
    wr(2, 6);
    wr(4, 8'h1D);
    ticks(2, "R7 before pause");
    wr(4, 8'h0D);
    ticks(5, "R7 paused");
    rd(2, "R7 saved count");
    wr(4, 8'h1D);
    ticks(4, "R7 resume expiry");
    rd(2, "R7 after expiry");

    // R8 zero reload guard on channel 3 (timer mode)
    wr(3, 0);
    wr(4, 8'hDD);
    ticks(5, "R8 zero start guard");
    rd(3, "R8 zero count");
    wr(3, 2);
    ticks(3, "R8 no start without enable edge");
    wr(4, 8'h1D);
    wr(4, 8'hDD);
    ticks(3, "R8 run with reload 2");
    wr(3, 0);
    ticks(4, "R8 stop on zero reload");
    rd(3, "R8 stopped");

    // R10 simultaneous expiries
    wr(4, 8'h00);
    wr(0, 4); wr(2, 4); wr(1, 4);
    wr(4, 8'h15);
    rd(1, "R7 ch1 resumed count");
    ticks(6, "R10 simultaneous expiry");
    for (int a = 0; a < 5; a++) rd(a, "R10 final reads");

    step(1'b0, "R3"); step(1'b0, "R3");
    chk(q.size() == 0, "R3 pending expiries", 32'(q.size()), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule